// File: doc/BRIEF.md
# Correlated Multiple Sampling Sequencer

This block runs one column's readout in a low-noise image sensor that uses multiple sampling. A switched-capacitor integrator and a column converter sit outside it. On a start strobe it clears the integrator while the pixel's sense node is reset. It then runs a burst of M sample-and-transfer cycles on the pixel's reset level and has the converter digitise the integrator output. Next it clears the integrator again and opens the transfer gate for a programmable gap. A second burst of M cycles on the photo-signal level follows, and then a second conversion.

The two codes go into separate registers. The block then publishes their signed difference, signal minus reset. This digital subtraction cancels column offset and reset noise. Larger M gives more analog gain and lower noise, at the cost of more time per row. The gap sets how far apart the two bursts are, which affects how well low-frequency noise is suppressed. M and the gap are captured when a frame starts.

Top module: `cms_sequencer`

## Requirements
- R1: While `rstN` is low and right after it is released, every phase, strobe and `adcStart` output is low, `busy` and `resultValid` are low, and `result` is 0.
- R2: A `startReq` seen while idle begins a frame. The frame opens with `phiRst` and `pixRst` both high for exactly 2 clocks. `pixRst` is never high without `phiRst`.
- R3: One sampling cycle is 6 clocks. First `phi1` and `phi1d` are high for 2 clocks, then `phi1d` alone for 1 clock. Then `phi2` and `phi2d` are high for 2 clocks, then `phi2d` alone for 1 clock. `phi1` and `phi2` are never high in the same clock.
- R4: Each burst has exactly M sampling cycles, so a frame has 2·M rising edges of `phi1`. M is `sampleCount` captured at the start edge, and a value of 0 counts as 1.
- R5: `adcStart` is a one-clock pulse issued right after each burst. The first pulse is seen 3 + 6·M clocks after the start edge. The block waits any number of clocks for `adcDone`, and it captures `adcCode` on the clock where `adcDone` is high.
- R6: Between the two bursts, `phiRst` and `pixTx` are high together with `pixRst` low, for max(`gapLen`, 1) clocks. `gapLen` is captured at the start edge.
- R7: `result` is the signal code minus the reset code, as a (CODE_W+1)-bit two's-complement value. It is negative when the signal code is the smaller of the two.
- R8: `resultValid` is high for exactly one clock. That clock comes two clocks after the edge that sampled the second `adcDone`. `result` holds its value after that.
- R9: A `startReq` during a frame is ignored. Changes to `sampleCount` or `gapLen` during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a frame when idle |
| sampleCount | input | M_W | Samples per level (M) |
| gapLen | input | GAP_W | Clocks between the two bursts |
| adcDone | input | 1 | Converter finished; code is valid |
| adcCode | input | CODE_W | Converter output code |
| phiRst | output | 1 | Integrator reset switch |
| phi1 | output | 1 | Input sampling switch |
| phi1d | output | 1 | Delayed input sampling switch |
| phi2 | output | 1 | Charge transfer switch |
| phi2d | output | 1 | Delayed charge transfer switch |
| pixRst | output | 1 | Pixel sense-node reset |
| pixTx | output | 1 | Pixel transfer gate |
| adcStart | output | 1 | Converter start pulse |
| busy | output | 1 | Frame in progress |
| resultValid | output | 1 | One-clock result strobe |
| result | output | CODE_W+1 | Signed signal minus reset code |

## Verification
All phase and strobe outputs are decoded from the registered state, so each one changes one clock after the edge that causes it. The first `adcStart` is therefore due 3 + 6·M clocks after the start edge. `resultValid` is due two clocks after the edge that accepts the final `adcDone`, because the block passes through one finishing state and then one result register. The bench samples on falling edges and counts those clocks. It answers the converter handshake from the same loop, so both the expected codes and the expected arrival clocks come from its own count of transfer pulses since the last integrator reset.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INT_RST,
    ST_PH1,
    ST_PH1_TAIL,
    ST_PH2,
    ST_PH2_TAIL,
    ST_CONV_REQ,
    ST_CONV_WAIT,
    ST_GAP,
    ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic capRst;
    logic capSig;
    logic publish;
  } dpCtrl_t;

endpackage

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int M_W        = 8,
  parameter int GAP_W      = 9,
  parameter int RST_CLKS   = 2,
  parameter int PHASE_CLKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [M_W-1:0]   sampleCount,
  input  logic [GAP_W-1:0] gapLen,
  input  logic             adcDone,
  output logic             phiRst,
  output logic             phi1,
  output logic             phi1d,
  output logic             phi2,
  output logic             phi2d,
  output logic             pixRst,
  output logic             pixTx,
  output logic             adcStart,
  output logic             busy,
  output dpCtrl_t          dpCtl
);

  localparam int GAP_MAX = (1 << GAP_W);
  localparam int SUB_MAX = (GAP_MAX > RST_CLKS) ?
                           ((GAP_MAX > PHASE_CLKS) ? GAP_MAX : PHASE_CLKS) :
                           ((RST_CLKS > PHASE_CLKS) ? RST_CLKS : PHASE_CLKS);
  localparam int SUB_W   = $clog2(SUB_MAX + 1);

  seqState_t        state;
  logic [SUB_W-1:0] subCnt;
  logic [M_W-1:0]   sampCnt;
  logic [M_W-1:0]   mReg;
  logic [GAP_W-1:0] gapReg;
  logic             level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subCnt  <= '0;
      sampCnt <= '0;
      mReg    <= M_W'(1);
      gapReg  <= GAP_W'(1);
      level   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_INT_RST;
            subCnt <= '0;
            level  <= 1'b0;
            mReg   <= (sampleCount == '0) ? M_W'(1) : sampleCount;
            gapReg <= (gapLen == '0) ? GAP_W'(1) : gapLen;
          end
        end
        ST_INT_RST: begin
          if (subCnt == SUB_W'(RST_CLKS - 1)) begin
            state   <= ST_PH1;
            subCnt  <= '0;
            sampCnt <= '0;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_PH1: begin
          if (subCnt == SUB_W'(PHASE_CLKS - 1)) begin
            state  <= ST_PH1_TAIL;
            subCnt <= '0;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_PH1_TAIL: state <= ST_PH2;
        ST_PH2: begin
          if (subCnt == SUB_W'(PHASE_CLKS - 1)) begin
            state  <= ST_PH2_TAIL;
            subCnt <= '0;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_PH2_TAIL: begin
          if (sampCnt == mReg - 1'b1) begin
            state <= ST_CONV_REQ;
          end else begin
            sampCnt <= sampCnt + 1'b1;
            state   <= ST_PH1;
          end
        end
        ST_CONV_REQ: state <= ST_CONV_WAIT;
        ST_CONV_WAIT: begin
          if (adcDone) begin
            subCnt <= '0;
            state  <= level ? ST_FINISH : ST_GAP;
          end
        end
        ST_GAP: begin
          if (subCnt == SUB_W'(gapReg - 1'b1)) begin
            state   <= ST_PH1;
            level   <= 1'b1;
            subCnt  <= '0;
            sampCnt <= '0;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    phiRst   = (state == ST_INT_RST) || (state == ST_GAP);
    pixRst   = (state == ST_INT_RST);
    pixTx    = (state == ST_GAP);
    phi1     = (state == ST_PH1);
    phi1d    = (state == ST_PH1) || (state == ST_PH1_TAIL);
    phi2     = (state == ST_PH2);
    phi2d    = (state == ST_PH2) || (state == ST_PH2_TAIL);
    adcStart = (state == ST_CONV_REQ);
    busy     = (state != ST_IDLE);
    dpCtl.capRst  = (state == ST_CONV_WAIT) && adcDone && !level;
    dpCtl.capSig  = (state == ST_CONV_WAIT) && adcDone && level;
    dpCtl.publish = (state == ST_FINISH);
  end

endmodule

// File: rtl/cms_datapath.sv
module cms_datapath
  import cms_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  dpCtl,
  input  logic [CODE_W-1:0]        adcCode,
  output logic                     resultValid,
  output logic signed [CODE_W:0]   result
);

  logic [CODE_W-1:0] rstCode;
  logic [CODE_W-1:0] sigCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstCode     <= '0;
      sigCode     <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      if (dpCtl.capRst) rstCode <= adcCode;
      if (dpCtl.capSig) sigCode <= adcCode;
      resultValid <= dpCtl.publish;
      if (dpCtl.publish) begin
        result <= $signed({1'b0, sigCode}) - $signed({1'b0, rstCode});
      end
    end
  end

endmodule

// File: rtl/cms_sequencer.sv
module cms_sequencer
  import cms_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int M_W        = 8,
  parameter int GAP_W      = 9,
  parameter int RST_CLKS   = 2,
  parameter int PHASE_CLKS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [M_W-1:0]         sampleCount,
  input  logic [GAP_W-1:0]       gapLen,
  input  logic                   adcDone,
  input  logic [CODE_W-1:0]      adcCode,
  output logic                   phiRst,
  output logic                   phi1,
  output logic                   phi1d,
  output logic                   phi2,
  output logic                   phi2d,
  output logic                   pixRst,
  output logic                   pixTx,
  output logic                   adcStart,
  output logic                   busy,
  output logic                   resultValid,
  output logic signed [CODE_W:0] result
);

  dpCtrl_t dpCtl;

  cms_ctrl #(
    .M_W        (M_W),
    .GAP_W      (GAP_W),
    .RST_CLKS   (RST_CLKS),
    .PHASE_CLKS (PHASE_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .sampleCount (sampleCount),
    .gapLen      (gapLen),
    .adcDone     (adcDone),
    .phiRst      (phiRst),
    .phi1        (phi1),
    .phi1d       (phi1d),
    .phi2        (phi2),
    .phi2d       (phi2d),
    .pixRst      (pixRst),
    .pixTx       (pixTx),
    .adcStart    (adcStart),
    .busy        (busy),
    .dpCtl       (dpCtl)
  );

  cms_datapath #(
    .CODE_W (CODE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dpCtl       (dpCtl),
    .adcCode     (adcCode),
    .resultValid (resultValid),
    .result      (result)
  );

endmodule

// File: rtl/cms_sequencer_chk.sv
module cms_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic phiRst,
  input logic phi1,
  input logic phi1d,
  input logic phi2,
  input logic phi2d,
  input logic pixRst,
  input logic pixTx,
  input logic adcStart,
  input logic resultValid
);

  // R3
  phase_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(phi1 && phi2));

  // R3
  phi1d_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phi1d && !phi1) |=> !phi1d);

  // R3
  phi2d_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phi2d && !phi2) |=> !phi2d);

  // R3
  phi1_fall_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phi1) |-> phi1d);

  // R3
  dead_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phi2) |-> !$past(phi1));

  // R2
  pix_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixRst |-> phiRst);

  // R6
  gap_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixTx |-> (phiRst && !pixRst && !phi1 && !phi2));

  // R5
  adc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

bind cms_sequencer cms_sequencer_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .phiRst      (phiRst),
  .phi1        (phi1),
  .phi1d       (phi1d),
  .phi2        (phi2),
  .phi2d       (phi2d),
  .pixRst      (pixRst),
  .pixTx       (pixTx),
  .adcStart    (adcStart),
  .resultValid (resultValid)
);

// File: tb/cms_sequencer_bench.sv
module cms_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 12;
  localparam int M_W        = 8;
  localparam int GAP_W      = 9;
  localparam int RST_CLKS   = 2;
  localparam int CYCLE_CLKS = 6;

  logic                   clk;
  logic                   rstN;
  logic                   startReq;
  logic [M_W-1:0]         sampleCount;
  logic [GAP_W-1:0]       gapLen;
  logic                   adcDone;
  logic [CODE_W-1:0]      adcCode;
  logic                   phiRst, phi1, phi1d, phi2, phi2d;
  logic                   pixRst, pixTx, adcStart, busy, resultValid;
  logic signed [CODE_W:0] result;

  int checks = 0;
  int errors = 0;

  cms_sequencer u_cms_sequencer (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .sampleCount (sampleCount),
    .gapLen      (gapLen),
    .adcDone     (adcDone),
    .adcCode     (adcCode),
    .phiRst      (phiRst),
    .phi1        (phi1),
    .phi1d       (phi1d),
    .phi2        (phi2),
    .phi2d       (phi2d),
    .pixRst      (pixRst),
    .pixTx       (pixTx),
    .adcStart    (adcStart),
    .busy        (busy),
    .resultValid (resultValid),
    .result      (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    startReq = 1'b0;
    adcDone = 1'b0;
    adcCode = '0;
    sampleCount = 8'd4;
    gapLen = 9'd4;
    repeat (3) @(negedge clk);
    // R1 state during reset
    checkEq("R1", "outputs in reset",
            int'({phiRst, phi1, phi1d, phi2, phi2d, pixRst, pixTx, adcStart, busy, resultValid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 state after release
    checkEq("R1", "outputs after release",
            int'({phiRst, phi1, phi1d, phi2, phi2d, pixRst, pixTx, adcStart, busy, resultValid}), 0);
    checkEq("R1", "result after release", int'(result), 0);
  endtask

  task automatic runFrame(input string name, input int m, input int gap, input int rstLvl,
                          input int sigLvl, input int lat, input bit disturb);
    int mm = (m == 0) ? 1 : m;
    int gg = (gap == 0) ? 1 : gap;
    int cyc = 1;
    int xfer = 0;
    int firstStart = -1;
    int startCount = 0;
    int phi1Rises = 0;
    int pixTxCnt = 0;
    int pixRstCnt = 0;
    int overlap = 0;
    int tailErr = 0;
    int convIdx = 0;
    bit pend = 0;
    int waitCnt = 0;
    int doneCyc = -100;
    int validCyc = -1;
    int validCount = 0;
    bit prevPhi1 = 0, prevPhi2 = 0, prevPhi1d = 0, prevPhi2d = 0;
    int lastResult = 0;

    $display("frame %s", name);
    @(negedge clk);
    sampleCount = M_W'(m);
    gapLen = GAP_W'(gap);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (cyc < 20000 && (validCyc < 0 || cyc < validCyc + 3)) begin
      if (phi1 && phi2) overlap++;
      if (phi1 && !prevPhi1) phi1Rises++;
      if (prevPhi1 && !phi1 && !phi1d) tailErr++;
      if (prevPhi2 && !phi2 && !phi2d) tailErr++;
      if (prevPhi1d && !prevPhi1 && phi1d && !phi1) tailErr++;
      if (prevPhi2d && !prevPhi2 && phi2d && !phi2) tailErr++;
      if (pixTx) pixTxCnt++;
      if (pixRst) pixRstCnt++;
      if (phi2 && !prevPhi2) xfer++;
      if (phiRst) xfer = 0;
      adcDone = 1'b0;
      if (adcStart) begin
        startCount++;
        if (firstStart < 0) firstStart = cyc;
        pend = 1;
        waitCnt = lat;
      end else if (pend) begin
        if (waitCnt == 0) begin
          adcDone = 1'b1;
          adcCode = CODE_W'(((convIdx == 0) ? rstLvl : sigLvl) * xfer);
          convIdx++;
          pend = 0;
          doneCyc = cyc;
        end else begin
          waitCnt--;
        end
      end
      if (resultValid) begin
        validCount++;
        if (validCyc < 0) begin
          validCyc = cyc;
          lastResult = int'(result);
        end
      end
      if (disturb && cyc == 10) begin
        startReq = 1'b1;
        sampleCount = 8'd3;
        gapLen = 9'd5;
      end
      if (disturb && cyc == 11) startReq = 1'b0;
      prevPhi1 = phi1;
      prevPhi2 = phi2;
      prevPhi1d = phi1d;
      prevPhi2d = phi2d;
      @(negedge clk);
      cyc++;
    end
    checkEq("R2", "pixel reset clocks", pixRstCnt, RST_CLKS);
    checkEq("R3", "phase overlaps", overlap, 0);
    checkEq("R3", "delayed phase timing errors", tailErr, 0);
    checkEq("R4", "phi1 rising edges", phi1Rises, 2 * mm);
    checkEq("R5", "first adcStart clock", firstStart, RST_CLKS + 1 + mm * CYCLE_CLKS);
    checkEq("R5", "adcStart pulses", startCount, 2);
    checkEq("R6", "transfer gate clocks", pixTxCnt, gg);
    checkEq("R7", "result value", lastResult, (sigLvl - rstLvl) * mm);
    checkEq("R8", "valid delay after done", validCyc - doneCyc, 2);
    checkEq("R8", "valid pulses", validCount, 1);
    checkEq("R8", "result held", int'(result), (sigLvl - rstLvl) * mm);
    if (disturb) begin
      // R9 the mid-frame start and input changes left this frame intact
      checkEq("R9", "busy after frame", int'(busy), 0);
      checkEq("R9", "result under disturbance", lastResult, (sigLvl - rstLvl) * mm);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    runFrame("small M long gap", 2, 268, 100, 400, 0, 1'b0);
    runFrame("mid M", 16, 16, 20, 90, 3, 1'b0);
    runFrame("large M negative", 128, 16, 30, 12, 5, 1'b0);
    runFrame("zero M zero gap", 0, 0, 7, 2000, 1, 1'b0);
    runFrame("start while busy", 4, 10, 50, 60, 2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule